// File: doc/BRIEF.md
# Bank-Switchable Two-Port Word Memory

This block is a two-port word memory whose storage is split into equal banks. Each bank belongs to exactly one of the two ports. A vector of bank-ownership inputs, driven from outside the block, decides which port owns each bank. Each port has its own controls:

- bank address and word address;
- chip enable and mailbox select;
- write strobe and output enable;
- upper and lower byte enables.

A port can read and write only the banks it owns. A write to a bank held by the other port is dropped. A read from such a bank returns zero and raises an error flag. Because of this, the two ports can never collide on a word, and they can both write in the same cycle without stalling.

The memory is synchronous to one clock. Writes take effect at the clock edge. Read data is registered and appears one cycle after the request. Alongside the read data, each port has two lane-valid bits that show which byte lanes carry data. The default word depth per bank is kept small for simulation. Setting `WORD_AW` to 14 gives banks of 16K words.

Top module: `bank_switch_dpram`

## Requirements
- R1: When `bank_own[n]` is 1, bank n belongs to the left port; when it is 0, bank n belongs to the right port. The owning port reads back what it wrote to that bank.
- R2: A write by a port to a bank it does not own leaves the stored word unchanged.
- R3: A read by a port from a bank it does not own gives, one cycle later, all-zero read data, lane-valid `2'b00` and the port's error flag at 1. The flag is 0 after any other request and after an idle cycle.
- R4: On a write, the upper enable stores bits 15:8 and the lower enable stores bits 7:0. With both enables at 0, nothing is stored.
- R5: On an owned read with output enable at 1, lane-valid bit 1 equals the upper enable and bit 0 equals the lower enable. A disabled lane reads back as zero.
- R6: A read with output enable at 0 gives zero read data and lane-valid `2'b00`.
- R7: A port accesses memory only when its chip enable is 1 and its mailbox select is 0. Otherwise it writes nothing, and one cycle later it shows zero data, lane-valid `2'b00` and no error.
- R8: Read data and lane-valid reflect the request from the previous clock edge. A cycle with no read request is followed by zero data and lane-valid `2'b00`.
- R9: Any split of ownership is allowed, from zero to all four banks per port. Stored contents survive a change of owner.
- R10: The left and right ports may write different banks in the same cycle, and both writes take effect.
- R11: Changing the owner of one bank does not disturb accesses that other banks serve in the same cycle.
- R12: While reset is active and right after it, read data, lane-valid and error outputs are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset of the read-side registers |
| bank_own | input | NB | Bank ownership; 1 gives the bank to the left port, 0 to the right port |
| lt_ce | input | 1 | Left chip enable |
| lt_mbsel | input | 1 | Left mailbox select; 1 blocks memory access |
| lt_we | input | 1 | Left write strobe; 0 means read |
| lt_oe | input | 1 | Left output enable |
| lt_ub | input | 1 | Left upper byte enable |
| lt_lb | input | 1 | Left lower byte enable |
| lt_bank | input | BW | Left bank address |
| lt_addr | input | WORD_AW | Left word address within the bank |
| lt_wdata | input | 2*LANE_W | Left write data |
| lt_rdata | output | 2*LANE_W | Left registered read data |
| lt_lane_vld | output | 2 | Left lane-valid; bit 1 is the upper lane, bit 0 the lower lane |
| lt_err | output | 1 | Left error flag for a read from an unowned bank |
| rt_ce | input | 1 | Right chip enable |
| rt_mbsel | input | 1 | Right mailbox select; 1 blocks memory access |
| rt_we | input | 1 | Right write strobe; 0 means read |
| rt_oe | input | 1 | Right output enable |
| rt_ub | input | 1 | Right upper byte enable |
| rt_lb | input | 1 | Right lower byte enable |
| rt_bank | input | BW | Right bank address |
| rt_addr | input | WORD_AW | Right word address within the bank |
| rt_wdata | input | 2*LANE_W | Right write data |
| rt_rdata | output | 2*LANE_W | Right registered read data |
| rt_lane_vld | output | 2 | Right lane-valid; bit 1 is the upper lane, bit 0 the lower lane |
| rt_err | output | 1 | Right error flag for a read from an unowned bank |

## Verification
The assertions assume that no port ever raises its chip enable and its mailbox select together. Every stimulus in the bench keeps at least one of the two low, so mailbox select is only exercised while chip enable is 0.

The assertions also assume that ownership inputs are stable across the clock edge at which a request is taken. The bench changes `bank_own` only at the falling edge, together with the requests it belongs to. It reads a word only after writing it, so no output depends on uninitialised storage.

// File: rtl/bank_switch_dpram.sv
module bank_switch_dpram #(
  parameter int NB      = 4,
  parameter int WORD_AW = 8,
  parameter int LANE_W  = 8
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [NB-1:0]                 bank_own,
  input  logic                          lt_ce,
  input  logic                          lt_mbsel,
  input  logic                          lt_we,
  input  logic                          lt_oe,
  input  logic                          lt_ub,
  input  logic                          lt_lb,
  input  logic [((NB>1)?$clog2(NB):1)-1:0] lt_bank,
  input  logic [WORD_AW-1:0]            lt_addr,
  input  logic [2*LANE_W-1:0]           lt_wdata,
  output logic [2*LANE_W-1:0]           lt_rdata,
  output logic [1:0]                    lt_lane_vld,
  output logic                          lt_err,
  input  logic                          rt_ce,
  input  logic                          rt_mbsel,
  input  logic                          rt_we,
  input  logic                          rt_oe,
  input  logic                          rt_ub,
  input  logic                          rt_lb,
  input  logic [((NB>1)?$clog2(NB):1)-1:0] rt_bank,
  input  logic [WORD_AW-1:0]            rt_addr,
  input  logic [2*LANE_W-1:0]           rt_wdata,
  output logic [2*LANE_W-1:0]           rt_rdata,
  output logic [1:0]                    rt_lane_vld,
  output logic                          rt_err
);
  localparam int BW    = (NB > 1) ? $clog2(NB) : 1;
  localparam int DW    = 2 * LANE_W;
  localparam int DEPTH = 1 << WORD_AW;

  logic lt_go, rt_go, lt_own, rt_own;
  assign lt_go  = lt_ce & ~lt_mbsel;
  assign rt_go  = rt_ce & ~rt_mbsel;
  assign lt_own = bank_own[lt_bank];
  assign rt_own = ~bank_own[rt_bank];

  logic [NB-1:0][DW-1:0] bank_q;

  for (genvar g = 0; g < NB; g++) begin : g_bank
    logic               use_lt, hit, we, ub, lb;
    logic [WORD_AW-1:0] addr;
    logic [DW-1:0]      wd;
    logic [DW-1:0]      q;
    logic [LANE_W-1:0]  hi_mem [DEPTH];
    logic [LANE_W-1:0]  lo_mem [DEPTH];

    assign use_lt = bank_own[g];
    assign hit  = use_lt ? (lt_go && lt_bank == BW'(g)) : (rt_go && rt_bank == BW'(g));
    assign we   = use_lt ? lt_we    : rt_we;
    assign ub   = use_lt ? lt_ub    : rt_ub;
    assign lb   = use_lt ? lt_lb    : rt_lb;
    assign addr = use_lt ? lt_addr  : rt_addr;
    assign wd   = use_lt ? lt_wdata : rt_wdata;

    always_ff @(posedge clk) begin
      if (hit && we && ub) hi_mem[addr] <= wd[DW-1:LANE_W];
      if (hit && we && lb) lo_mem[addr] <= wd[LANE_W-1:0];
      if (hit && !we)      q <= {hi_mem[addr], lo_mem[addr]};
    end

    assign bank_q[g] = q;
  end

  logic [BW-1:0] lt_bank_r, rt_bank_r;
  logic [1:0]    lt_lane_r, rt_lane_r;
  logic          lt_err_r, rt_err_r;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lt_bank_r <= '0;
      lt_lane_r <= '0;
      lt_err_r  <= 1'b0;
      rt_bank_r <= '0;
      rt_lane_r <= '0;
      rt_err_r  <= 1'b0;
    end else begin
      lt_bank_r <= lt_bank;
      lt_lane_r <= (lt_go && !lt_we && lt_own && lt_oe) ? {lt_ub, lt_lb} : 2'b00;
      lt_err_r  <= lt_go && !lt_we && !lt_own;
      rt_bank_r <= rt_bank;
      rt_lane_r <= (rt_go && !rt_we && rt_own && rt_oe) ? {rt_ub, rt_lb} : 2'b00;
      rt_err_r  <= rt_go && !rt_we && !rt_own;
    end
  end

  logic [DW-1:0] lt_word, rt_word;
  assign lt_word = bank_q[lt_bank_r];
  assign rt_word = bank_q[rt_bank_r];

  assign lt_rdata    = {lt_lane_r[1] ? lt_word[DW-1:LANE_W] : '0,
                        lt_lane_r[0] ? lt_word[LANE_W-1:0]  : '0};
  assign rt_rdata    = {rt_lane_r[1] ? rt_word[DW-1:LANE_W] : '0,
                        rt_lane_r[0] ? rt_word[LANE_W-1:0]  : '0};
  assign lt_lane_vld = lt_lane_r;
  assign rt_lane_vld = rt_lane_r;
  assign lt_err      = lt_err_r;
  assign rt_err      = rt_err_r;
endmodule

// File: rtl/bank_switch_dpram_chk.sv
module bank_switch_dpram_chk #(
  parameter int NB = 4,
  parameter int BW = 2,
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic [NB-1:0] bank_own,
  input logic          lt_ce, lt_mbsel, lt_we, lt_oe, lt_ub, lt_lb,
  input logic [BW-1:0] lt_bank,
  input logic [DW-1:0] lt_rdata,
  input logic [1:0]    lt_lane_vld,
  input logic          lt_err,
  input logic          rt_ce, rt_mbsel, rt_we, rt_oe, rt_ub, rt_lb,
  input logic [BW-1:0] rt_bank,
  input logic [DW-1:0] rt_rdata,
  input logic [1:0]    rt_lane_vld,
  input logic          rt_err
);
  logic lt_rd, rt_rd;
  assign lt_rd = lt_ce && !lt_mbsel && !lt_we;
  assign rt_rd = rt_ce && !rt_mbsel && !rt_we;

  a_r7_excl_lt: assert property (@(posedge clk) disable iff (!rst_n) !(lt_ce && lt_mbsel));
  a_r7_excl_rt: assert property (@(posedge clk) disable iff (!rst_n) !(rt_ce && rt_mbsel));

  a_r3_foreign_read_lt: assert property (@(posedge clk) disable iff (!rst_n)
    (lt_rd && !bank_own[lt_bank]) |=> (lt_err && lt_rdata == '0 && lt_lane_vld == 2'b00));
  a_r3_foreign_read_rt: assert property (@(posedge clk) disable iff (!rst_n)
    (rt_rd && bank_own[rt_bank]) |=> (rt_err && rt_rdata == '0 && rt_lane_vld == 2'b00));

  a_r5_lanes_lt: assert property (@(posedge clk) disable iff (!rst_n)
    (lt_rd && lt_oe && bank_own[lt_bank]) |=> (!lt_err && lt_lane_vld == $past({lt_ub, lt_lb})));
  a_r5_lanes_rt: assert property (@(posedge clk) disable iff (!rst_n)
    (rt_rd && rt_oe && !bank_own[rt_bank]) |=> (!rt_err && rt_lane_vld == $past({rt_ub, rt_lb})));

  a_r6_oe_off_lt: assert property (@(posedge clk) disable iff (!rst_n)
    (lt_rd && !lt_oe) |=> (lt_lane_vld == 2'b00 && lt_rdata == '0));
  a_r6_oe_off_rt: assert property (@(posedge clk) disable iff (!rst_n)
    (rt_rd && !rt_oe) |=> (rt_lane_vld == 2'b00 && rt_rdata == '0));

  a_r8_idle_lt: assert property (@(posedge clk) disable iff (!rst_n)
    !lt_rd |=> (lt_lane_vld == 2'b00 && lt_rdata == '0 && !lt_err));
  a_r8_idle_rt: assert property (@(posedge clk) disable iff (!rst_n)
    !rt_rd |=> (rt_lane_vld == 2'b00 && rt_rdata == '0 && !rt_err));
endmodule

bind bank_switch_dpram bank_switch_dpram_chk u_chk (
  .clk(clk), .rst_n(rst_n), .bank_own(bank_own),
  .lt_ce(lt_ce), .lt_mbsel(lt_mbsel), .lt_we(lt_we), .lt_oe(lt_oe), .lt_ub(lt_ub), .lt_lb(lt_lb),
  .lt_bank(lt_bank), .lt_rdata(lt_rdata), .lt_lane_vld(lt_lane_vld), .lt_err(lt_err),
  .rt_ce(rt_ce), .rt_mbsel(rt_mbsel), .rt_we(rt_we), .rt_oe(rt_oe), .rt_ub(rt_ub), .rt_lb(rt_lb),
  .rt_bank(rt_bank), .rt_rdata(rt_rdata), .rt_lane_vld(rt_lane_vld), .rt_err(rt_err)
);

// File: tb/sim_bank_switch_dpram.sv
module sim_bank_switch_dpram;
  localparam int CLK_P = 10;

  typedef struct packed {
    logic [15:0] tag;
    logic [3:0]  own;
    logic        rp;
    logic        we;
    logic [1:0]  bank;
    logic [7:0]  addr;
    logic        ub, lb, oe;
    logic [15:0] wd, erd;
    logic [1:0]  ev;
    logic        ee;
  } vec_t;

  localparam int NV = 18;
  localparam vec_t TBL [NV] = '{
    '{"R1", 4'b0011, 1'b0, 1'b1, 2'd0, 8'd5, 1'b1, 1'b1, 1'b1, 16'h1234, 16'h0000, 2'b00, 1'b0},
    '{"R1", 4'b0011, 1'b0, 1'b0, 2'd0, 8'd5, 1'b1, 1'b1, 1'b1, 16'h0000, 16'h1234, 2'b11, 1'b0},
    '{"R2", 4'b0011, 1'b1, 1'b1, 2'd0, 8'd5, 1'b1, 1'b1, 1'b1, 16'hFFFF, 16'h0000, 2'b00, 1'b0},
    '{"R2", 4'b0011, 1'b0, 1'b0, 2'd0, 8'd5, 1'b1, 1'b1, 1'b1, 16'h0000, 16'h1234, 2'b11, 1'b0},
    '{"R3", 4'b0011, 1'b1, 1'b0, 2'd0, 8'd5, 1'b1, 1'b1, 1'b1, 16'h0000, 16'h0000, 2'b00, 1'b1},
    '{"R4", 4'b0011, 1'b1, 1'b1, 2'd2, 8'd7, 1'b1, 1'b1, 1'b1, 16'h5566, 16'h0000, 2'b00, 1'b0},
    '{"R4", 4'b0011, 1'b1, 1'b1, 2'd2, 8'd7, 1'b1, 1'b0, 1'b1, 16'hABCD, 16'h0000, 2'b00, 1'b0},
    '{"R4", 4'b0011, 1'b1, 1'b1, 2'd2, 8'd7, 1'b0, 1'b1, 1'b1, 16'h11EE, 16'h0000, 2'b00, 1'b0},
    '{"R4", 4'b0011, 1'b1, 1'b1, 2'd2, 8'd7, 1'b0, 1'b0, 1'b1, 16'h0000, 16'h0000, 2'b00, 1'b0},
    '{"R4", 4'b0011, 1'b1, 1'b0, 2'd2, 8'd7, 1'b1, 1'b1, 1'b1, 16'h0000, 16'hABEE, 2'b11, 1'b0},
    '{"R5", 4'b0011, 1'b1, 1'b0, 2'd2, 8'd7, 1'b1, 1'b0, 1'b1, 16'h0000, 16'hAB00, 2'b10, 1'b0},
    '{"R5", 4'b0011, 1'b1, 1'b0, 2'd2, 8'd7, 1'b0, 1'b1, 1'b1, 16'h0000, 16'h00EE, 2'b01, 1'b0},
    '{"R6", 4'b0011, 1'b1, 1'b0, 2'd2, 8'd7, 1'b1, 1'b1, 1'b0, 16'h0000, 16'h0000, 2'b00, 1'b0},
    '{"R9", 4'b1111, 1'b0, 1'b1, 2'd3, 8'd9, 1'b1, 1'b1, 1'b1, 16'hC0DE, 16'h0000, 2'b00, 1'b0},
    '{"R9", 4'b1111, 1'b0, 1'b0, 2'd3, 8'd9, 1'b1, 1'b1, 1'b1, 16'h0000, 16'hC0DE, 2'b11, 1'b0},
    '{"R9", 4'b0000, 1'b1, 1'b0, 2'd3, 8'd9, 1'b1, 1'b1, 1'b1, 16'h0000, 16'hC0DE, 2'b11, 1'b0},
    '{"R9", 4'b0000, 1'b1, 1'b0, 2'd0, 8'd5, 1'b1, 1'b1, 1'b1, 16'h0000, 16'h1234, 2'b11, 1'b0},
    '{"R9", 4'b0000, 1'b0, 1'b0, 2'd1, 8'd0, 1'b1, 1'b1, 1'b1, 16'h0000, 16'h0000, 2'b00, 1'b1}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  bank_own = '0;
  logic        lt_ce = 0, lt_mbsel = 0, lt_we = 0, lt_oe = 0, lt_ub = 0, lt_lb = 0;
  logic [1:0]  lt_bank = '0;
  logic [7:0]  lt_addr = '0;
  logic [15:0] lt_wdata = '0;
  logic [15:0] lt_rdata;
  logic [1:0]  lt_lane_vld;
  logic        lt_err;
  logic        rt_ce = 0, rt_mbsel = 0, rt_we = 0, rt_oe = 0, rt_ub = 0, rt_lb = 0;
  logic [1:0]  rt_bank = '0;
  logic [7:0]  rt_addr = '0;
  logic [15:0] rt_wdata = '0;
  logic [15:0] rt_rdata;
  logic [1:0]  rt_lane_vld;
  logic        rt_err;

  int n_chk = 0;
  int n_fail = 0;

  always #(CLK_P/2) clk = ~clk;

  bank_switch_dpram u0 (
    .clk(clk), .rst_n(rst_n), .bank_own(bank_own),
    .lt_ce(lt_ce), .lt_mbsel(lt_mbsel), .lt_we(lt_we), .lt_oe(lt_oe), .lt_ub(lt_ub), .lt_lb(lt_lb),
    .lt_bank(lt_bank), .lt_addr(lt_addr), .lt_wdata(lt_wdata),
    .lt_rdata(lt_rdata), .lt_lane_vld(lt_lane_vld), .lt_err(lt_err),
    .rt_ce(rt_ce), .rt_mbsel(rt_mbsel), .rt_we(rt_we), .rt_oe(rt_oe), .rt_ub(rt_ub), .rt_lb(rt_lb),
    .rt_bank(rt_bank), .rt_addr(rt_addr), .rt_wdata(rt_wdata),
    .rt_rdata(rt_rdata), .rt_lane_vld(rt_lane_vld), .rt_err(rt_err)
  );

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: got %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic idle();
    lt_ce = 0; lt_mbsel = 0; lt_we = 0; lt_oe = 0; lt_ub = 0; lt_lb = 0;
    rt_ce = 0; rt_mbsel = 0; rt_we = 0; rt_oe = 0; rt_ub = 0; rt_lb = 0;
  endtask

  task automatic drive_lt(input logic we, input logic [1:0] b, input logic [7:0] a,
                          input logic ub, input logic lb, input logic oe, input logic [15:0] wd);
    lt_ce = 1; lt_mbsel = 0; lt_we = we; lt_bank = b; lt_addr = a;
    lt_ub = ub; lt_lb = lb; lt_oe = oe; lt_wdata = wd;
  endtask

  task automatic drive_rt(input logic we, input logic [1:0] b, input logic [7:0] a,
                          input logic ub, input logic lb, input logic oe, input logic [15:0] wd);
    rt_ce = 1; rt_mbsel = 0; rt_we = we; rt_bank = b; rt_addr = a;
    rt_ub = ub; rt_lb = lb; rt_oe = oe; rt_wdata = wd;
  endtask

  task automatic edge_sample();
    @(posedge clk);
    #1;
  endtask

  initial begin
    #(CLK_P * 20000);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk + 1);
    $finish;
  end

  initial begin
    idle();
    repeat (3) @(posedge clk);
    #1;
    // R12: outputs clear under reset
    chk("R12", "lt_rdata", 32'(lt_rdata), 32'h0);
    chk("R12", "lt_lane_vld", 32'(lt_lane_vld), 32'h0);
    chk("R12", "lt_err", 32'(lt_err), 32'h0);
    chk("R12", "rt_lane_vld", 32'(rt_lane_vld), 32'h0);
    chk("R12", "rt_err", 32'(rt_err), 32'h0);
    @(negedge clk);
    rst_n = 1'b1;
    edge_sample();
    chk("R12", "rt_rdata after release", 32'(rt_rdata), 32'h0);

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      idle();
      bank_own = TBL[i].own;
      if (TBL[i].rp)
        drive_rt(TBL[i].we, TBL[i].bank, TBL[i].addr, TBL[i].ub, TBL[i].lb, TBL[i].oe, TBL[i].wd);
      else
        drive_lt(TBL[i].we, TBL[i].bank, TBL[i].addr, TBL[i].ub, TBL[i].lb, TBL[i].oe, TBL[i].wd);
      edge_sample();
      if (TBL[i].rp) begin
        chk(string'(TBL[i].tag), "rt_rdata", 32'(rt_rdata), 32'(TBL[i].erd));
        chk(string'(TBL[i].tag), "rt_lane_vld", 32'(rt_lane_vld), 32'(TBL[i].ev));
        chk(string'(TBL[i].tag), "rt_err", 32'(rt_err), 32'(TBL[i].ee));
      end else begin
        chk(string'(TBL[i].tag), "lt_rdata", 32'(lt_rdata), 32'(TBL[i].erd));
        chk(string'(TBL[i].tag), "lt_lane_vld", 32'(lt_lane_vld), 32'(TBL[i].ev));
        chk(string'(TBL[i].tag), "lt_err", 32'(lt_err), 32'(TBL[i].ee));
      end
    end

    // R7: chip enable low blocks writes, mailbox select blocks access
    @(negedge clk);
    idle();
    bank_own = 4'b0011;
    drive_lt(1, 2'd0, 8'd5, 1, 1, 1, 16'hDEAD);
    lt_ce = 0;
    edge_sample();
    @(negedge clk);
    drive_lt(1, 2'd0, 8'd5, 1, 1, 1, 16'hBEEF);
    lt_ce = 0; lt_mbsel = 1;
    edge_sample();
    @(negedge clk);
    drive_lt(0, 2'd0, 8'd5, 1, 1, 1, 16'h0);
    lt_ce = 0;
    edge_sample();
    chk("R7", "lt_lane_vld ce low", 32'(lt_lane_vld), 32'h0);
    chk("R7", "lt_err ce low", 32'(lt_err), 32'h0);
    @(negedge clk);
    drive_lt(0, 2'd0, 8'd5, 1, 1, 1, 16'h0);
    // R8: nothing visible before the edge
    #1;
    chk("R8", "lt_lane_vld before edge", 32'(lt_lane_vld), 32'h0);
    edge_sample();
    chk("R7", "lt_rdata kept", 32'(lt_rdata), 32'h1234);
    @(negedge clk);
    idle();
    edge_sample();
    chk("R8", "lt_lane_vld after idle", 32'(lt_lane_vld), 32'h0);
    chk("R8", "lt_rdata after idle", 32'(lt_rdata), 32'h0);

    // R10: both ports write in one cycle
    @(negedge clk);
    bank_own = 4'b0101;
    drive_lt(1, 2'd2, 8'd3, 1, 1, 1, 16'h1111);
    drive_rt(1, 2'd1, 8'd3, 1, 1, 1, 16'h2222);
    edge_sample();
    @(negedge clk);
    drive_lt(0, 2'd2, 8'd3, 1, 1, 1, 16'h0);
    drive_rt(0, 2'd1, 8'd3, 1, 1, 1, 16'h0);
    edge_sample();
    chk("R10", "lt_rdata", 32'(lt_rdata), 32'h1111);
    chk("R10", "rt_rdata", 32'(rt_rdata), 32'h2222);

    // R11: bank 0 moves to the right port while banks 2 and 1 keep serving
    @(negedge clk);
    bank_own = 4'b0100;
    edge_sample();
    chk("R11", "lt_rdata", 32'(lt_rdata), 32'h1111);
    chk("R11", "lt_err", 32'(lt_err), 32'h0);
    chk("R11", "rt_rdata", 32'(rt_rdata), 32'h2222);
    @(negedge clk);
    drive_rt(0, 2'd0, 8'd5, 1, 1, 1, 16'h0);
    edge_sample();
    chk("R11", "rt_rdata moved bank", 32'(rt_rdata), 32'h1234);
    chk("R11", "lt_rdata still", 32'(lt_rdata), 32'h1111);

    @(negedge clk);
    idle();
    edge_sample();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule